// File: doc/BRIEF.md
# Mailbox Receive Identifier Matcher

This block chooses the receive mailbox for a CAN identifier once a frame has finished arriving. It keeps a parameterised set of mailbox entries. Each entry has an identifier register, a mask register and a two-bit state. When a receive-done strobe arrives, the block compares the incoming identifier against every entry under that entry's mask. The lowest-numbered Active entry that matches takes the frame: the entry becomes Full and stores the received identifier. If no Active entry matches but a Full entry does, an overflow is reported with the index of that Full entry. If nothing matches, the frame is dropped and no indication is given.

A host uses a simple write port to configure each entry's identifier, mask and state. A separate release strobe returns a Full entry to Active once its payload has been consumed. Payload storage lives outside this block; the result index returned here is what addresses it. A combinational read port exposes any entry so that the host can see what the block recorded.

Top module: `mbox_id_match`

## Requirements
- R1: An entry matches identifier V when ((V XOR entry_id) AND entry_mask) is zero. For example, id 0x12345678 with mask 0xFFFFFF00 matches every V of the form 0x123456xx and no other V.
- R2: State codes are 2'b00 Inactive, 2'b01 Active, 2'b10 Full and 2'b11 Invalid. After reset every entry is Inactive and its id and mask are zero.
- R3: When rx_done is high, the lowest-index matching Active entry is accepted. In the next cycle res_accept is 1 and res_idx carries that index.
- R4: An accepted entry becomes Full and its id field takes the received identifier. Its mask does not change.
- R5: When no Active entry matches but at least one Full entry does, res_ovf is 1 in the next cycle and res_idx is the lowest matching Full index. No entry changes.
- R6: When no entry matches, neither res_accept nor res_ovf rises and no entry changes.
- R7: Inactive and Invalid entries never match, whatever their id and mask.
- R8: A release (rel_valid with rel_idx) moves a Full entry to Active and leaves any entry in another state unchanged.
- R9: A host write with cfg_we sets one field of entry cfg_idx: cfg_sel 0 writes the id, 1 writes the mask, 2 writes the state from cfg_wdata[1:0]. If the entry is accepted in the same cycle, the acceptance wins for id and state.
- R10: A release issued in the same cycle as rx_done takes effect after the search. The search therefore sees the entry's state before the release.
- R11: res_accept and res_ovf are never high together, and each lasts exactly one cycle per rx_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Host configuration write strobe |
| cfg_sel | input | 2 | Field select: 0 id, 1 mask, 2 state |
| cfg_idx | input | IDX_W | Entry addressed by the write |
| cfg_wdata | input | ID_W | Write data |
| rel_valid | input | 1 | Release strobe |
| rel_idx | input | IDX_W | Entry to release |
| rx_done | input | 1 | Receive-done strobe |
| rx_id | input | ID_W | Received identifier |
| rd_idx | input | IDX_W | Entry shown on the read port |
| rd_id | output | ID_W | Id of entry rd_idx |
| rd_mask | output | ID_W | Mask of entry rd_idx |
| rd_state | output | 2 | State of entry rd_idx |
| res_accept | output | 1 | Frame accepted, one-cycle pulse |
| res_ovf | output | 1 | Overflow, one-cycle pulse |
| res_idx | output | IDX_W | Index for accept or overflow |

## Verification
Two pairs of events can land in the same cycle. A host release can coincide with the search, and a host id write can coincide with an acceptance into the same entry. The bench pulses rx_done together with a release of a Full entry that is also the lowest match. It expects an overflow on that entry, then Active state on readback, then an acceptance on the following frame. It also writes an id into the entry being accepted in the same cycle and expects the received identifier to survive. Expected results come from a bench-side model of the requirements, which is also applied to a long sweep of overlapping identifiers and interleaved releases.

// File: rtl/mbox_pkg.sv
// Shared types for the mailbox identifier matcher.
// Assumes: the state encoding below is visible to the host on rd_state.
package mbox_pkg;
    typedef enum logic [1:0] {
        MB_INACTIVE = 2'b00,
        MB_ACTIVE   = 2'b01,
        MB_FULL     = 2'b10,
        MB_INVALID  = 2'b11
    } mbox_state_t;

    localparam logic [1:0] SEL_ID    = 2'd0;
    localparam logic [1:0] SEL_MASK  = 2'd1;
    localparam logic [1:0] SEL_STATE = 2'd2;
endpackage

// File: rtl/mbox_entry.sv
// One mailbox entry: id, mask and state registers plus the masked compare.
// Assumes: acc is asserted only for an entry that is Active, and rel only
// moves Full entries. Acceptance outranks a host write in the same cycle.
module mbox_entry
    import mbox_pkg::*;
#(
    parameter int ID_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_id,
    input  logic            we_mask,
    input  logic            we_state,
    input  logic [ID_W-1:0] wdata,
    input  logic            rel,
    input  logic            acc,
    input  logic [ID_W-1:0] rx_id,
    output logic            hit,
    output logic            is_active,
    output logic            is_full,
    output logic [ID_W-1:0] id_q,
    output logic [ID_W-1:0] mask_q,
    output mbox_state_t     state_q
);

    // Masked identifier comparison
    always_comb begin
        hit = (((rx_id ^ id_q) & mask_q) == '0);
    end

    // State decode for the search
    always_comb begin
        is_active = (state_q == MB_ACTIVE);
        is_full   = (state_q == MB_FULL);
    end

    // Identifier register: captured on acceptance, else host write
    always_ff @(posedge clk) begin
        if (!rst_n)       id_q <= '0;
        else if (acc)     id_q <= rx_id;
        else if (we_id)   id_q <= wdata;
    end

    // Mask register: host write only
    always_ff @(posedge clk) begin
        if (!rst_n)        mask_q <= '0;
        else if (we_mask)  mask_q <= wdata;
    end

    // State register: accept > host write > release
    always_ff @(posedge clk) begin
        if (!rst_n)                      state_q <= MB_INACTIVE;
        else if (acc)                    state_q <= MB_FULL;
        else if (we_state)               state_q <= mbox_state_t'(wdata[1:0]);
        else if (rel && state_q == MB_FULL) state_q <= MB_ACTIVE;
    end

    // R4
    // accept_from_active_chk
    accept_from_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> state_q == MB_ACTIVE);

    // R7
    // idle_state_hold_chk
    idle_state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == MB_INACTIVE || state_q == MB_INVALID) && !we_state)
        |=> $stable(state_q));

    // R8
    // release_full_chk
    release_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel && state_q == MB_FULL && !acc && !we_state) |=> state_q == MB_ACTIVE);

endmodule

// File: rtl/mbox_first_pick.sv
// Lowest-index picker over a request vector.
// Assumes: N >= 2; idx is zero when nothing is requested.
module mbox_first_pick #(
    parameter int N     = 16,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top down so the lowest requester is assigned last
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/mbox_id_match.sv
// Mailbox receive identifier matcher (top).
// Searches all entries on rx_done; accepts into the lowest matching Active
// entry, else reports overflow on the lowest matching Full entry, else drops.
// Results are registered: visible the cycle after rx_done.
// Assumes: host writes and releases may arrive in any cycle, including the
// cycle of a search; the search always sees pre-edge state.
module mbox_id_match
    import mbox_pkg::*;
#(
    parameter int NUM_MBOX = 16,
    parameter int ID_W     = 32,
    localparam int IDX_W   = $clog2(NUM_MBOX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [ID_W-1:0]  cfg_wdata,
    input  logic             rel_valid,
    input  logic [IDX_W-1:0] rel_idx,
    input  logic             rx_done,
    input  logic [ID_W-1:0]  rx_id,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [ID_W-1:0]  rd_id,
    output logic [ID_W-1:0]  rd_mask,
    output logic [1:0]       rd_state,
    output logic             res_accept,
    output logic             res_ovf,
    output logic [IDX_W-1:0] res_idx
);

    logic [NUM_MBOX-1:0] hit_v, act_v, full_v, acc_v;
    logic [ID_W-1:0]     id_a   [NUM_MBOX];
    logic [ID_W-1:0]     mask_a [NUM_MBOX];
    mbox_state_t         st_a   [NUM_MBOX];

    logic             act_found, full_found;
    logic [IDX_W-1:0] act_idx, full_idx;

    genvar g;
    generate
        for (g = 0; g < NUM_MBOX; g++) begin : g_ent
            logic sel_me;
            // Address decode for this entry
            always_comb sel_me = cfg_we && (cfg_idx == IDX_W'(g));

            mbox_entry #(.ID_W(ID_W)) u_ent (
                .clk       (clk),
                .rst_n     (rst_n),
                .we_id     (sel_me && cfg_sel == SEL_ID),
                .we_mask   (sel_me && cfg_sel == SEL_MASK),
                .we_state  (sel_me && cfg_sel == SEL_STATE),
                .wdata     (cfg_wdata),
                .rel       (rel_valid && rel_idx == IDX_W'(g)),
                .acc       (acc_v[g]),
                .rx_id     (rx_id),
                .hit       (hit_v[g]),
                .is_active (act_v[g]),
                .is_full   (full_v[g]),
                .id_q      (id_a[g]),
                .mask_q    (mask_a[g]),
                .state_q   (st_a[g])
            );
        end
    endgenerate

    mbox_first_pick #(.N(NUM_MBOX)) u_pick_act (
        .req   (hit_v & act_v),
        .found (act_found),
        .idx   (act_idx)
    );

    mbox_first_pick #(.N(NUM_MBOX)) u_pick_full (
        .req   (hit_v & full_v),
        .found (full_found),
        .idx   (full_idx)
    );

    // One-hot acceptance strobe toward the winning entry
    always_comb begin
        acc_v = '0;
        if (rx_done && act_found) acc_v[act_idx] = 1'b1;
    end

    // Registered result: accept, overflow or silent drop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_accept <= 1'b0;
            res_ovf    <= 1'b0;
            res_idx    <= '0;
        end else begin
            res_accept <= rx_done && act_found;
            res_ovf    <= rx_done && !act_found && full_found;
            if (rx_done)
                res_idx <= act_found ? act_idx : (full_found ? full_idx : '0);
        end
    end

    // Host read port
    always_comb begin
        rd_id    = id_a[rd_idx];
        rd_mask  = mask_a[rd_idx];
        rd_state = st_a[rd_idx];
    end

    // R11
    // exclusive_result_chk
    exclusive_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_accept && res_ovf));

    // R11
    // result_follows_rx_chk
    result_follows_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_accept || res_ovf) |-> $past(rx_done));

    // R4
    // accepted_is_full_chk
    accepted_is_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_accept |-> st_a[res_idx] == MB_FULL);

    // R3
    // single_accept_chk
    single_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(acc_v));

    // R5
    // overflow_leaves_state_chk
    overflow_leaves_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !act_found) |-> acc_v == '0);

endmodule

// File: tb/mbox_id_match_test.sv
`timescale 1ns/1ps
module mbox_id_match_test;
    localparam int N  = 16;
    localparam int IW = 4;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          cfg_we = 0;
    logic [1:0]    cfg_sel = 0;
    logic [IW-1:0] cfg_idx = 0;
    logic [31:0]   cfg_wdata = 0;
    logic          rel_valid = 0;
    logic [IW-1:0] rel_idx = 0;
    logic          rx_done = 0;
    logic [31:0]   rx_id = 0;
    logic [IW-1:0] rd_idx = 0;
    logic [31:0]   rd_id, rd_mask;
    logic [1:0]    rd_state;
    logic          res_accept, res_ovf;
    logic [IW-1:0] res_idx;

    int tests = 0, fails = 0;
    logic [31:0] m_id [N];
    logic [31:0] m_mask [N];
    logic [1:0]  m_st [N];

    always #2 clk = ~clk;

    mbox_id_match #(.NUM_MBOX(N), .ID_W(32)) uut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg(input int idx, input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_idx = IW'(idx); cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
        if (sel == 0) m_id[idx] = d;
        else if (sel == 1) m_mask[idx] = d;
        else m_st[idx] = d[1:0];
    endtask

    task automatic setup(input int idx, input logic [31:0] id, input logic [31:0] mk, input logic [1:0] st);
        cfg(idx, 0, id); cfg(idx, 1, mk); cfg(idx, 2, st);
    endtask

    task automatic release_e(input int idx);
        @(negedge clk);
        rel_valid = 1; rel_idx = IW'(idx);
        @(negedge clk);
        rel_valid = 0;
        if (m_st[idx] == 2'b10) m_st[idx] = 2'b01;
    endtask

    task automatic peek(input string req, input int idx);
        rd_idx = IW'(idx);
        #0.1;
        check(req, rd_id, m_id[idx]);
        check(req, {30'd0, rd_state}, {30'd0, m_st[idx]});
    endtask

    // Frame arrival with optional same-cycle release and same-cycle id write.
    task automatic frame(input string req, input logic [31:0] v,
                         input bit rel_en, input int rel_i,
                         input bit cw_en, input int cw_i, input logic [31:0] cw_d);
        int ea = -1, ef = -1;
        logic [1:0] pre_rel;
        for (int i = 0; i < N; i++) begin
            if (((v ^ m_id[i]) & m_mask[i]) == 0) begin
                if (m_st[i] == 2'b01 && ea < 0) ea = i;
                if (m_st[i] == 2'b10 && ef < 0) ef = i;
            end
        end
        pre_rel = rel_en ? m_st[rel_i] : 2'b00;
        @(negedge clk);
        rx_done = 1; rx_id = v;
        rel_valid = rel_en; rel_idx = IW'(rel_i);
        cfg_we = cw_en; cfg_sel = 0; cfg_idx = IW'(cw_i); cfg_wdata = cw_d;
        @(negedge clk);
        rx_done = 0; rel_valid = 0; cfg_we = 0;
        check({req, " accept"}, {31'd0, res_accept}, {31'd0, ea >= 0});
        check({req, " ovf"}, {31'd0, res_ovf}, {31'd0, ea < 0 && ef >= 0});
        if (ea >= 0) check({req, " idx"}, {28'd0, res_idx}, 32'(ea));
        else if (ef >= 0) check({req, " idx"}, {28'd0, res_idx}, 32'(ef));
        if (cw_en) m_id[cw_i] = cw_d;
        if (ea >= 0) begin m_st[ea] = 2'b10; m_id[ea] = v; end
        if (rel_en && pre_rel == 2'b10) m_st[rel_i] = 2'b01;
    endtask

    task automatic rx1(input string req, input logic [31:0] v);
        frame(req, v, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #800000;
        tests++; fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_id[i] = 0; m_mask[i] = 0; m_st[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R2: reset state of every entry
        for (int i = 0; i < N; i++) begin
            rd_idx = IW'(i); #0.1;
            check("R2 reset", {rd_id, rd_mask} == 64'd0 && rd_state == 2'b00, 32'd1);
        end
        check("R2 reset result", {30'd0, res_accept, res_ovf}, 32'd0);
        // R7: all Inactive with zero mask would match anything
        rx1("R7 inactive", 32'h0);
        // R1, R4: mask example
        setup(0, 32'h12345678, 32'hFFFFFF00, 2'b01);
        rx1("R1 R3 mask match", 32'h123456AB);
        peek("R4 captured id", 0);
        rd_idx = 0; #0.1; check("R4 mask kept", rd_mask, 32'hFFFFFF00);
        rx1("R6 miss", 32'h123457AB);
        rx1("R5 overflow", 32'h12345600);
        peek("R5 state kept", 0);
        setup(2, 32'h12345600, 32'hFFFFFF00, 2'b11);
        setup(3, 32'h12345600, 32'hFFFFFF00, 2'b01);
        rx1("R3 R7 skip invalid", 32'h12345611);
        release_e(0); peek("R8 release full", 0);
        release_e(5); peek("R8 release inactive", 5);
        release_e(2); peek("R8 release invalid", 2);
        rx1("R3 lowest wins", 32'h12345622);
        // R10: release of the lowest Full entry in the search cycle
        frame("R10 collide", 32'h12345633, 1, 0, 0, 0, 0);
        peek("R10 after release", 0);
        rx1("R10 next accept", 32'h12345634);
        release_e(0);
        // R9: id write to the entry being accepted in the same cycle
        frame("R9 collide", 32'h12345644, 0, 0, 1, 0, 32'hDEADBEEF);
        peek("R9 accept wins", 0);
        frame("R9 other entry", 32'h12345655, 0, 0, 1, 9, 32'h0BADF00D);
        peek("R9 write other", 9);
        // R11: pulses end after one cycle
        @(negedge clk);
        check("R11 pulse width", {30'd0, res_accept, res_ovf}, 32'd0);
        // Sweep: overlapping ids, mixed states, interleaved releases
        for (int k = 0; k < N; k++)
            setup(k, 32'h55000000 + 32'(k % 6) * 32'h100,
                  (k < 8) ? 32'hFFFFFF00 : 32'hFFFF0000,
                  (k == 7) ? 2'b11 : ((k % 5 == 3) ? 2'b00 : 2'b01));
        for (int j = 0; j < 160; j++) begin
            frame("R1 R3 R5 R6 R7 sweep", 32'h55000000 + 32'(j % 8) * 32'h100 + 32'(j),
                  (j % 3 == 0), (j * 7) % N, 0, 0, 0);
            if (j % 10 == 0) for (int k = 0; k < N; k++) peek("R4 R8 sweep", k);
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule